// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Register Slave

This block is the configuration front end of a larger chip. A host writes a bank of 8-bit control registers through three shared pins: a chip-enable pin, a clock pin and a data pin. The block decides at run time which protocol to speak on these pins. After reset it acts as a two-wire slave, with the clock pin as SCL and the data pin as an open-drain SDA. In that mode the chip-enable pin is a static address strap. The first high-to-low transition on the chip-enable pin switches the block permanently into a write-only SPI slave. It stays in SPI mode until the next reset.

All three pins are sampled with the system clock through synchronizers. The block never drives the data pin high. It only raises a pull-down enable that the pad turns into a low level. The register contents are brought out on a flat bus for the rest of the chip. Writing register 0 with its top bit set returns every register to its reset value.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 0 holds 0x06, register 1 holds 0x1C, register 8 holds 0x80 and every other register holds 0x00. The block starts in two-wire mode, so `spi_mode_o` is 0.
- R2: A high-to-low edge on `ce_i`, seen after reset, sets `spi_mode_o` to 1. The mode then holds until reset, even when `ce_i` rises again. A `ce_i` that is already low when reset ends does not select SPI. In SPI mode, `cdata_pull_o` stays 0.
- R3: An SPI frame lasts while `ce_i` is low. The block samples 24 bits on rising `cclk_i` edges, MSB first. The first byte is the chip address 0010000 followed by the R/W bit, the second byte is the register address and the third byte is the data. A write happens only when the address matches and R/W is 0. Frames with any other first byte, frames cut short by `ce_i` rising, and bits after the 24th are all ignored.
- R4: In two-wire mode the slave address is 001000x, where x is the level of `ce_i`. On a matching address the block acknowledges by holding `cdata_pull_o` at 1 through the ninth SCL pulse.
- R5: A two-wire frame whose address does not match gets no acknowledge and causes no write. SDA stays released until the next START.
- R6: A two-wire write is the address byte with R/W=0, then the register byte, then the data byte, and all three are acknowledged. The data byte is stored at the end of its eighth bit. Any further byte in the same frame is not acknowledged and has no effect.
- R7: A two-wire read is a frame with R/W=1. It returns, MSB first, the register named by the most recent register byte. The block changes SDA only while SCL is low.
- R8: Address 4 and every address of 16 or above hold no register. Writes to them are dropped and reads from them return 0x00.
- R9: Writing a value with bit 7 set to register 0, through either port, returns every register to its R1 value.
- R10: `regs_o` bits [8n+7:8n] carry register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip-enable pin; SPI select, or address strap in two-wire mode |
| cclk_i | input | 1 | Serial clock pin (SPI clock or SCL) |
| cdata_i | input | 1 | Serial data pin level as seen on the wire |
| cdata_pull_o | output | 1 | Open-drain pull-down enable for the data pin |
| spi_mode_o | output | 1 | 1 once SPI mode has been selected |
| regs_o | output | 128 | Flat register contents, register n at [8n+7:8n] |

## Verification
The bench targets the mode decision. It checks that `ce_i` held low through reset does not select SPI, since a design that did would lose the two-wire port whenever the strap is tied low. It also checks that `ce_i` rising after an SPI frame does not fall back to two-wire mode. Frame edges are exercised with truncated SPI frames, SPI frames with the wrong chip address or R/W=1, and an extra two-wire byte after the data byte. A design that got these wrong would write spurious registers or acknowledge bytes it should refuse. Further cases are acknowledge timing for both strap levels, mismatched addresses, reads through a repeated START, unimplemented addresses and the soft reset through both ports. A mismatched address caught wrongly would pull SDA low on a foreign frame, and a faulty soft reset would leave register 0 or 8 stale.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int          BYTE_W         = 8;
    localparam logic [5:0]  CHIP_ID        = 6'b001000;
    localparam int unsigned HOLE_ADDR      = 4;
    localparam int          SPI_FRAME_BITS = 3 * BYTE_W;

    typedef enum logic [2:0] {
        TW_IDLE,
        TW_RX,
        TW_ACK,
        TW_TX,
        TW_TX_ACK
    } tw_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_REG,
        BK_DATA
    } tw_kind_e;

    function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h06;
            1:       return 8'h1C;
            8:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic reg_present(input logic [BYTE_W-1:0] addr,
                                         input int unsigned       nregs);
        return ({24'd0, addr} < nregs) && ({24'd0, addr} != HOLE_ADDR);
    endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int             N        = 3,
    parameter logic [N-1:0]   IDLE_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
        logic [1:0]   prime;
    } sync_t;

    sync_t q, d;
    logic  armed;

    always_comb begin
        d       = q;
        d.s1    = pins_i;
        d.s2    = q.s1;
        d.prev  = q.s2;
        d.prime = (q.prime == 2'd3) ? q.prime : q.prime + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1    <= IDLE_VAL;
            q.s2    <= IDLE_VAL;
            q.prev  <= IDLE_VAL;
            q.prime <= 2'd0;
        end else begin
            q <= d;
        end
    end

    assign armed = (q.prime == 2'd3);

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign level_o[i] = q.s2[i];
        assign rise_o[i]  = armed &  q.s2[i] & ~q.prev[i];
        assign fall_o[i]  = armed & ~q.s2[i] &  q.prev[i];
    end

endmodule

// File: rtl/cfg_spi_rx.sv
module cfg_spi_rx
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cs_level_i,
    input  logic              cs_fall_i,
    input  logic              sck_rise_i,
    input  logic              sdi_i,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam int CNT_W = $clog2(SPI_FRAME_BITS + 1);

    typedef struct packed {
        logic [SPI_FRAME_BITS-1:0] shift;
        logic [CNT_W-1:0]          cnt;
        logic                      wr_en;
        logic [BYTE_W-1:0]         addr;
        logic [BYTE_W-1:0]         data;
    } spi_t;

    spi_t q, d;
    logic [SPI_FRAME_BITS-1:0] next_shift;
    logic [BYTE_W-1:0]         head;

    always_comb begin
        d          = q;
        d.wr_en    = 1'b0;
        next_shift = {q.shift[SPI_FRAME_BITS-2:0], sdi_i};
        head       = next_shift[SPI_FRAME_BITS-1 -: BYTE_W];
        if (cs_level_i || cs_fall_i) begin
            d.cnt = '0;
        end else if (en_i && sck_rise_i && (q.cnt < CNT_W'(SPI_FRAME_BITS))) begin
            d.shift = next_shift;
            d.cnt   = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(SPI_FRAME_BITS - 1)) begin
                if (head == {CHIP_ID, 1'b0, 1'b0}) begin
                    d.wr_en = 1'b1;
                    d.addr  = next_shift[2*BYTE_W-1 -: BYTE_W];
                    d.data  = next_shift[BYTE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.addr;
    assign wr_data_o = q.data;

    // R3: the bit counter never runs past one frame
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(SPI_FRAME_BITS));

    // R3: a write strobe only follows the last bit of a frame while selected
    a_r3_write_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.cnt == CNT_W'(SPI_FRAME_BITS)) && !cs_level_i);

endmodule

// File: rtl/cfg_twi_slave.sv
module cfg_twi_slave
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ad0_i,
    input  logic              scl_level_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_level_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              pull_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    typedef struct packed {
        tw_state_e         state;
        tw_kind_e          kind;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shift;
        logic              rw;
        logic [BYTE_W-1:0] ptr;
        logic              pull;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_data;
    } tw_t;

    tw_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (!en_i) begin
            d.state = TW_IDLE;
            d.pull  = 1'b0;
        end else if (scl_level_i && sda_fall_i) begin
            d.state = TW_RX;
            d.kind  = BK_ADDR;
            d.cnt   = '0;
            d.pull  = 1'b0;
        end else if (scl_level_i && sda_rise_i) begin
            d.state = TW_IDLE;
            d.pull  = 1'b0;
        end else begin
            case (q.state)
                TW_RX: begin
                    if (scl_rise_i && (q.cnt < 4'd8)) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_level_i};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall_i && (q.cnt == 4'd8)) begin
                        case (q.kind)
                            BK_ADDR: begin
                                if (q.shift[BYTE_W-1:1] == {CHIP_ID, ad0_i}) begin
                                    d.rw    = q.shift[0];
                                    d.pull  = 1'b1;
                                    d.state = TW_ACK;
                                end else begin
                                    d.state = TW_IDLE;
                                end
                            end
                            BK_REG: begin
                                d.ptr   = q.shift;
                                d.pull  = 1'b1;
                                d.state = TW_ACK;
                            end
                            default: begin
                                d.wr_en   = 1'b1;
                                d.wr_data = q.shift;
                                d.pull    = 1'b1;
                                d.state   = TW_ACK;
                            end
                        endcase
                    end
                end
                TW_ACK: begin
                    if (scl_fall_i) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        case (q.kind)
                            BK_ADDR: begin
                                if (q.rw) begin
                                    d.state = TW_TX;
                                    d.shift = rd_data_i;
                                    d.pull  = ~rd_data_i[BYTE_W-1];
                                end else begin
                                    d.state = TW_RX;
                                    d.kind  = BK_REG;
                                end
                            end
                            BK_REG: begin
                                d.state = TW_RX;
                                d.kind  = BK_DATA;
                            end
                            default: d.state = TW_IDLE;
                        endcase
                    end
                end
                TW_TX: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == 4'd8) begin
                            d.pull  = 1'b0;
                            d.state = TW_TX_ACK;
                        end else begin
                            d.pull  = ~q.shift[BYTE_W-2];
                            d.shift = {q.shift[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                TW_TX_ACK: begin
                    if (scl_fall_i) begin
                        d.state = TW_IDLE;
                    end
                end
                default: d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TW_IDLE;
            q.kind  <= BK_ADDR;
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign pull_o    = q.pull;
    assign wr_en_o   = q.wr_en;
    assign wr_data_o = q.wr_data;

    // R7: SDA is only changed by the slave while SCL is low
    a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && !$stable(q.pull)) |-> !scl_level_i);

    // R5: no pull-down while waiting for a START or after a refused address
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TW_IDLE) |-> !q.pull);

    // R6: a stored byte is acknowledged in the same step
    a_r6_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.state == TW_ACK) && q.pull);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [BYTE_W-1:0]            wr_addr_i,
    input  logic [BYTE_W-1:0]            wr_data_i,
    input  logic [BYTE_W-1:0]            rd_addr_i,
    output logic [BYTE_W-1:0]            rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q, regs_d;
    logic soft_reset;

    assign soft_reset = wr_en_i && (wr_addr_i == '0) && wr_data_i[BYTE_W-1];

    always_comb begin
        regs_d = regs_q;
        if (soft_reset) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_d[i] = reg_default(i);
            end
        end else if (wr_en_i && reg_present(wr_addr_i, NUM_REGS)) begin
            regs_d[wr_addr_i[IDX_W-1:0]] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data_o = reg_present(rd_addr_i, NUM_REGS) ? regs_q[rd_addr_i[IDX_W-1:0]] : '0;
    assign regs_o    = regs_q;

    // R9: a soft reset leaves the non-zero defaults in place one cycle later
    a_r9_soft_reset_restores: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (regs_q[0] == reg_default(0)) && (regs_q[1] == reg_default(1)));

    // R8: writes to holes leave the whole bank untouched
    a_r8_hole_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !reg_present(wr_addr_i, NUM_REGS)) |=> $stable(regs_q));

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_i,
    input  logic                       cclk_i,
    input  logic                       cdata_i,
    output logic                       cdata_pull_o,
    output logic                       spi_mode_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int PIN_CE  = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_DAT = 2;

    logic [2:0] lvl, rise, fall;

    typedef struct packed {
        logic spi_mode;
    } mode_t;

    mode_t q, d;

    logic              spi_wr_en, tw_wr_en, bank_wr_en;
    logic [BYTE_W-1:0] spi_addr, spi_data, tw_ptr, tw_data;
    logic [BYTE_W-1:0] bank_addr, bank_data, rd_data;
    logic              tw_pull;

    cfg_pin_sync #(.N(3), .IDLE_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  ({cdata_i, cclk_i, ce_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        d          = q;
        d.spi_mode = q.spi_mode | fall[PIN_CE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    cfg_spi_rx u_spi (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (q.spi_mode),
        .cs_level_i (lvl[PIN_CE]),
        .cs_fall_i  (fall[PIN_CE]),
        .sck_rise_i (rise[PIN_CLK]),
        .sdi_i      (lvl[PIN_DAT]),
        .wr_en_o    (spi_wr_en),
        .wr_addr_o  (spi_addr),
        .wr_data_o  (spi_data)
    );

    cfg_twi_slave u_twi (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (!q.spi_mode),
        .ad0_i       (lvl[PIN_CE]),
        .scl_level_i (lvl[PIN_CLK]),
        .scl_rise_i  (rise[PIN_CLK]),
        .scl_fall_i  (fall[PIN_CLK]),
        .sda_level_i (lvl[PIN_DAT]),
        .sda_rise_i  (rise[PIN_DAT]),
        .sda_fall_i  (fall[PIN_DAT]),
        .rd_data_i   (rd_data),
        .ptr_o       (tw_ptr),
        .pull_o      (tw_pull),
        .wr_en_o     (tw_wr_en),
        .wr_data_o   (tw_data)
    );

    assign bank_wr_en = q.spi_mode ? spi_wr_en : tw_wr_en;
    assign bank_addr  = q.spi_mode ? spi_addr  : tw_ptr;
    assign bank_data  = q.spi_mode ? spi_data  : tw_data;

    cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bank_wr_en),
        .wr_addr_i (bank_addr),
        .wr_data_i (bank_data),
        .rd_addr_i (tw_ptr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    assign cdata_pull_o = tw_pull & !q.spi_mode;
    assign spi_mode_o   = q.spi_mode;

    // R2: once selected, SPI mode holds until reset
    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.spi_mode |=> q.spi_mode);

    // R2: the two-wire engine is silent one cycle after SPI is chosen
    a_r2_no_pull_in_spi: assert property (@(posedge clk) disable iff (!rst_n)
        (q.spi_mode && $past(q.spi_mode)) |-> !tw_pull);

endmodule

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 12;
    localparam int NREGS      = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic ce, scl_drv, sda_drv;
    logic pull, spi_mode;
    logic [NREGS*8-1:0] regs;
    logic line;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [NREGS];

    assign line = sda_drv & ~pull;

    cfg_serial_slave #(.NUM_REGS(NREGS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_i         (ce),
        .cclk_i       (scl_drv),
        .cdata_i      (line),
        .cdata_pull_o (pull),
        .spi_mode_o   (spi_mode),
        .regs_o       (regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] def_val(input int idx);
        return (idx == 0) ? 8'h06 : (idx == 1) ? 8'h1C : (idx == 8) ? 8'h80 : 8'h00;
    endfunction

    function automatic logic is_real(input logic [7:0] a);
        return (a < 8'(NREGS)) && (a != 8'd4);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        return is_real(a) ? model[a[3:0]] : 8'h00;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREGS; i++) model[i] = def_val(i);
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'd0 && v[7]) model_reset();
        else if (is_real(a)) model[a[3:0]] = v;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREGS; i++)
            chk(req, $sformatf("reg%0d", i), {24'd0, regs[8*i +: 8]}, {24'd0, model[i]});
    endtask

    task automatic do_reset(input logic ce_val);
        rst_n = 1'b0; ce = ce_val; scl_drv = 1'b1; sda_drv = 1'b1;
        cyc(5);
        rst_n = 1'b1;
        cyc(10);
        model_reset();
    endtask

    task automatic tw_start();
        sda_drv = 1'b1; cyc(HB);
        scl_drv = 1'b1; cyc(HB);
        sda_drv = 1'b0; cyc(HB);
        scl_drv = 1'b0; cyc(HB);
    endtask

    task automatic tw_stop();
        sda_drv = 1'b0; cyc(HB);
        scl_drv = 1'b1; cyc(HB);
        sda_drv = 1'b1; cyc(HB);
    endtask

    task automatic tw_byte_out(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; cyc(HB);
            scl_drv = 1'b1; cyc(HB);
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1; cyc(HB);
        scl_drv = 1'b1; cyc(HB/2);
        ack = line;
        cyc(HB/2);
        scl_drv = 1'b0;
        cyc(2);
    endtask

    task automatic tw_byte_in(output logic [7:0] b, output logic moved_high);
        moved_high = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = 1'b1; cyc(HB);
            scl_drv = 1'b1; cyc(2);
            b[i] = line;
            for (int k = 0; k < HB - 2; k++) begin
                cyc(1);
                if (line !== b[i]) moved_high = 1'b1;
            end
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1; cyc(HB);
        scl_drv = 1'b1; cyc(HB);
        scl_drv = 1'b0; cyc(2);
    endtask

    task automatic tw_write(input logic [6:0] dev, input logic [7:0] a,
                            input logic [7:0] v, output logic [2:0] acks);
        tw_start();
        tw_byte_out({dev, 1'b0}, acks[2]);
        tw_byte_out(a, acks[1]);
        tw_byte_out(v, acks[0]);
        tw_stop();
        cyc(4);
    endtask

    task automatic tw_read(input logic [6:0] dev, input logic [7:0] a,
                           output logic [7:0] v, output logic [2:0] acks,
                           output logic bad_edge);
        tw_start();
        tw_byte_out({dev, 1'b0}, acks[2]);
        tw_byte_out(a, acks[1]);
        tw_start();
        tw_byte_out({dev, 1'b1}, acks[0]);
        tw_byte_in(v, bad_edge);
        tw_stop();
        cyc(4);
    endtask

    task automatic spi_frame(input logic [23:0] w, input int nbits, input int extra);
        scl_drv = 1'b0; cyc(HB);
        ce = 1'b0; cyc(HB);
        for (int i = 0; i < nbits + extra; i++) begin
            sda_drv = (i < 24) ? w[23 - i] : 1'b1;
            cyc(HB);
            scl_drv = 1'b1; cyc(HB);
            scl_drv = 1'b0;
        end
        cyc(HB);
        ce = 1'b1; cyc(HB);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [2:0] acks;
        logic [7:0] rv;
        logic       bad;
        logic       ackx;
        void'($urandom(32'h5EED_1234));

        // R1 reset state with strap high
        do_reset(1'b1);
        chk("R1", "mode after reset", {31'd0, spi_mode}, 32'd0);
        check_bank("R1");

        // R4 R6 R10 basic write, strap high -> address 0010001
        tw_write(7'b0010001, 8'h09, 8'hA5, acks);
        chk("R4", "acks addr/reg/data", {29'd0, acks}, 32'd0);
        model_write(8'h09, 8'hA5);
        chk("R10", "reg9 on bus", {24'd0, regs[8*9 +: 8]}, 32'h0000_00A5);

        // R7 readback
        tw_read(7'b0010001, 8'h09, rv, acks, bad);
        chk("R7", "read reg9", {24'd0, rv}, 32'h0000_00A5);
        chk("R7", "read acks", {29'd0, acks}, 32'd0);
        chk("R7", "sda stable while scl high", {31'd0, bad}, 32'd0);
        tw_read(7'b0010001, 8'h08, rv, acks, bad);
        chk("R7", "read reg8 default", {24'd0, rv}, 32'h0000_0080);

        // R5 foreign address, including the other strap value
        tw_write(7'b0010000, 8'h0A, 8'h5A, acks);
        chk("R5", "no ack for strap mismatch", {31'd0, acks[2]}, 32'd1);
        tw_write(7'b1010001, 8'h0B, 8'h33, acks);
        chk("R5", "no ack foreign device", {29'd0, acks}, 32'd7);
        check_bank("R5");

        // R6 extra byte after data is refused
        tw_start();
        tw_byte_out(8'b0010_0010, ackx);
        tw_byte_out(8'h0A, ackx);
        tw_byte_out(8'h3C, ackx);
        chk("R6", "data byte ack", {31'd0, ackx}, 32'd0);
        tw_byte_out(8'h77, ackx);
        chk("R6", "extra byte nack", {31'd0, ackx}, 32'd1);
        tw_stop();
        cyc(4);
        model_write(8'h0A, 8'h3C);
        check_bank("R6");

        // R8 holes
        tw_write(7'b0010001, 8'h04, 8'hFF, acks);
        tw_write(7'b0010001, 8'h20, 8'hEE, acks);
        check_bank("R8");
        tw_read(7'b0010001, 8'h04, rv, acks, bad);
        chk("R8", "read hole 4", {24'd0, rv}, 32'd0);
        tw_read(7'b0010001, 8'h20, rv, acks, bad);
        chk("R8", "read hole 0x20", {24'd0, rv}, 32'd0);

        // R9 soft reset over two-wire
        tw_write(7'b0010001, 8'h01, 8'h00, acks);
        model_write(8'h01, 8'h00);
        tw_write(7'b0010001, 8'h00, 8'h80, acks);
        model_write(8'h00, 8'h80);
        check_bank("R9");

        // random two-wire traffic
        for (int it = 0; it < 20; it++) begin
            logic [7:0] a, v;
            a = 8'($urandom_range(0, 19));
            v = 8'($urandom);
            tw_write(7'b0010001, a, v, acks);
            model_write(a, v);
            a = 8'($urandom_range(0, 19));
            tw_read(7'b0010001, a, rv, acks, bad);
            chk("R7", $sformatf("random read addr %0d", a), {24'd0, rv}, {24'd0, exp_read(a)});
        end
        check_bank("R6");

        // R2 R4 strap held low through reset stays in two-wire mode
        do_reset(1'b0);
        chk("R2", "low strap no spi", {31'd0, spi_mode}, 32'd0);
        tw_write(7'b0010000, 8'h0C, 8'h42, acks);
        chk("R4", "acks with strap low", {29'd0, acks}, 32'd0);
        model_write(8'h0C, 8'h42);
        tw_write(7'b0010001, 8'h0D, 8'h24, acks);
        chk("R4", "strap-high addr refused", {31'd0, acks[2]}, 32'd1);
        check_bank("R4");

        // SPI mode
        do_reset(1'b1);
        spi_frame({8'h20, 8'h0E, 8'h5D}, 24, 0);
        model_write(8'h0E, 8'h5D);
        chk("R2", "spi selected", {31'd0, spi_mode}, 32'd1);
        chk("R2", "pull idle in spi", {31'd0, pull}, 32'd0);
        check_bank("R3");
        spi_frame({8'h21, 8'h0F, 8'h11}, 24, 0);
        spi_frame({8'h22, 8'h0F, 8'h12}, 24, 0);
        spi_frame({8'h20, 8'h0F, 8'h13}, 16, 0);
        check_bank("R3");
        spi_frame({8'h20, 8'h05, 8'h99}, 24, 5);
        model_write(8'h05, 8'h99);
        check_bank("R3");
        spi_frame({8'h20, 8'h04, 8'h99}, 24, 0);
        check_bank("R8");
        for (int it = 0; it < 15; it++) begin
            logic [7:0] a, v;
            a = 8'($urandom_range(1, 19));
            v = 8'($urandom);
            spi_frame({8'h20, a, v}, 24, 0);
            model_write(a, v);
        end
        check_bank("R3");
        chk("R2", "mode held after ce high", {31'd0, spi_mode}, 32'd1);
        spi_frame({8'h20, 8'h00, 8'hC0}, 24, 0);
        model_write(8'h00, 8'hC0);
        check_bank("R9");
        chk("R2", "pull never in spi", {31'd0, pull}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule